// File: doc/BRIEF.md
# Taint Propagation Pipeline

This block follows retirement in a processor and keeps a metadata "taint" state for every architectural register. Each retired, non-speculative instruction enters a four-stage in-order pipe. Stage 1 asks an external filter table for a two-bit propagation code for the opcode. Stage 2 fetches the memory taint for loads. Stage 3 resolves the result: either quickly through the filter code, or through an external propagation cache that returns a state and an exception flag. Stage 4 writes the register taint or the memory taint and reports the instruction as done.

The state width is set at run time from 1 to 16 bits. When the pipe is disabled, instructions flow straight from the input to the done port and no taint state is touched. A cache-resolved instruction that reads the register written by the instruction directly ahead of it waits one cycle. A filter-resolved one takes the forwarded value instead and does not wait.

Top module: `taint_pipe`

## Requirements
- R1: An instruction accepted at clock edge k is reported on the done port during the cycle after edge k+3, and instructions complete in issue order.
- R2: Register 0 always reads as state zero. A write aimed at it has no effect, although the instruction still reports its computed state.
- R3: The filter code selects the resolution: 3 gives state zero; 1 gives zero when all three source states are zero and uses the cache otherwise; 2 gives zero when all are zero, the single nonzero source when exactly one is nonzero, and uses the cache otherwise; 0 always uses the cache.
- R4: A cache resolution presents the opcode, the two register source states and the memory source state. The returned state, masked to the configured width, becomes the result.
- R5: With width_cfg_i = w, states are w+1 bits wide. The memory taint read and every produced state are masked to that width.
- R6: With en_i low, in_ready_o is high and each input instruction appears on the done port in the same cycle with its tag, state zero and no exception. No register or memory taint changes.
- R7: A cache-resolved instruction whose source is the register written by the instruction directly ahead waits one cycle, so it completes two cycles after that instruction and uses its committed state.
- R8: A store holds stage 4 with a stable write address and data on the memory-taint write port until mt_ready_i is high. While it waits, in_ready_o is low and nothing is reported done.
- R9: done_exc_o is high only together with a done instruction, and only when its cache response carried the exception flag.
- R10: A filter-resolved instruction that depends on the instruction directly ahead uses the forwarded state and completes one cycle after it.
- R11: A load uses the memory taint at its address as its memory source, while other instructions use zero. A store writes its result to memory taint at its address, not to a register.
- R12: After reset all register states are zero, in_ready_o is high and nothing is reported done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Pipeline enable; low selects bypass |
| width_cfg_i | input | 4 | State width minus one |
| in_valid_i | input | 1 | Retired instruction valid |
| in_ready_o | output | 1 | Pipeline can accept an instruction |
| in_opc_i | input | OPCW | Opcode |
| in_rd_i | input | RIW | Destination register |
| in_rs1_i | input | RIW | First source register |
| in_rs2_i | input | RIW | Second source register |
| in_load_i | input | 1 | Instruction is a load |
| in_store_i | input | 1 | Instruction is a store |
| in_addr_i | input | AW | Data address of a load or store |
| in_tag_i | input | TAGW | Instruction tag |
| filt_opc_o | output | OPCW | Filter table lookup opcode (stage 1) |
| filt_code_i | input | 2 | Filter code for filt_opc_o |
| mt_rd_en_o | output | 1 | Memory taint read request (stage 2) |
| mt_rd_addr_o | output | AW | Memory taint read address |
| mt_rd_data_i | input | 16 | Memory taint read data |
| mt_we_o | output | 1 | Memory taint write request (stage 4) |
| mt_wr_addr_o | output | AW | Memory taint write address |
| mt_wr_data_o | output | 16 | Memory taint write data |
| mt_ready_i | input | 1 | Memory taint write can complete |
| tpc_req_o | output | 1 | Propagation cache lookup (stage 3) |
| tpc_opc_o | output | OPCW | Cache lookup opcode |
| tpc_s1_o | output | 16 | Cache lookup first register state |
| tpc_s2_o | output | 16 | Cache lookup second register state |
| tpc_sm_o | output | 16 | Cache lookup memory state |
| tpc_state_i | input | 16 | Cache result state |
| tpc_exc_i | input | 1 | Cache result exception flag |
| done_valid_o | output | 1 | Instruction completed |
| done_tag_o | output | TAGW | Tag of the completed instruction |
| done_state_o | output | 16 | Result state of the completed instruction |
| done_exc_o | output | 1 | Completed instruction raises an exception |

## Verification
The assertions assume three things. The filter table and the propagation cache answer in the same cycle they are asked. en_i and width_cfg_i change only while no instruction is in flight. A load never reads a memory-taint word that an older store still holds in stage 4. The bench responds to the filter and cache combinationally from their request ports, drains the pipe before it touches the enable or the width, and never loads an address that a store ahead of it has not yet written back.

// File: rtl/taint_pkg.sv
package taint_pkg;
  localparam int STW  = 16;
  localparam int CFGW = $clog2(STW);

  typedef enum logic [1:0] {
    FC_SLOW  = 2'b00,
    FC_ZOPT  = 2'b01,
    FC_UNARY = 2'b10,
    FC_CLEAR = 2'b11
  } fcode_e;

  function automatic logic [STW-1:0] width_mask(input logic [CFGW-1:0] w);
    return {STW{1'b1}} >> (STW - 1 - int'(w));
  endfunction
endpackage

// File: rtl/taint_regfile.sv
module taint_regfile
  import taint_pkg::*;
#(
  parameter int NREG = 32,
  parameter int RIW  = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [RIW-1:0] ra1_i,
  input  logic [RIW-1:0] ra2_i,
  output logic [STW-1:0] rd1_o,
  output logic [STW-1:0] rd2_o,
  input  logic           we_i,
  input  logic [RIW-1:0] wa_i,
  input  logic [STW-1:0] wd_i
);
  logic [STW-1:0] q [NREG];

  // entry 0 is never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      q[wa_i] <= wd_i;
    end
  end

  assign rd1_o = q[ra1_i];
  assign rd2_o = q[ra2_i];
endmodule

// File: rtl/taint_resolve.sv
module taint_resolve
  import taint_pkg::*;
(
  input  fcode_e         code_i,
  input  logic [STW-1:0] a_i,
  input  logic [STW-1:0] b_i,
  input  logic [STW-1:0] m_i,
  input  logic [STW-1:0] mask_i,
  input  logic [STW-1:0] cache_state_i,
  input  logic           cache_exc_i,
  output logic           need_cache_o,
  output logic [STW-1:0] state_o,
  output logic           exc_o
);
  logic [1:0]     nz;
  logic [STW-1:0] fast;

  always_comb begin
    nz = {1'b0, |a_i} + {1'b0, |b_i} + {1'b0, |m_i};
    need_cache_o = 1'b0;
    fast = '0;
    case (code_i)
      FC_CLEAR: fast = '0;
      FC_ZOPT:  need_cache_o = (nz != 2'd0);
      FC_UNARY: begin
        need_cache_o = (nz > 2'd1);
        fast = a_i | b_i | m_i;
      end
      default:  need_cache_o = 1'b1;
    endcase
    state_o = need_cache_o ? (cache_state_i & mask_i) : fast;
    exc_o   = need_cache_o & cache_exc_i;
  end
endmodule

// File: rtl/taint_pipe.sv
module taint_pipe
  import taint_pkg::*;
#(
  parameter int NREG = 32,
  parameter int AW   = 16,
  parameter int TAGW = 8,
  parameter int OPCW = 8,
  parameter int RIW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [CFGW-1:0] width_cfg_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [OPCW-1:0] in_opc_i,
  input  logic [RIW-1:0]  in_rd_i,
  input  logic [RIW-1:0]  in_rs1_i,
  input  logic [RIW-1:0]  in_rs2_i,
  input  logic            in_load_i,
  input  logic            in_store_i,
  input  logic [AW-1:0]   in_addr_i,
  input  logic [TAGW-1:0] in_tag_i,
  output logic [OPCW-1:0] filt_opc_o,
  input  logic [1:0]      filt_code_i,
  output logic            mt_rd_en_o,
  output logic [AW-1:0]   mt_rd_addr_o,
  input  logic [STW-1:0]  mt_rd_data_i,
  output logic            mt_we_o,
  output logic [AW-1:0]   mt_wr_addr_o,
  output logic [STW-1:0]  mt_wr_data_o,
  input  logic            mt_ready_i,
  output logic            tpc_req_o,
  output logic [OPCW-1:0] tpc_opc_o,
  output logic [STW-1:0]  tpc_s1_o,
  output logic [STW-1:0]  tpc_s2_o,
  output logic [STW-1:0]  tpc_sm_o,
  input  logic [STW-1:0]  tpc_state_i,
  input  logic            tpc_exc_i,
  output logic            done_valid_o,
  output logic [TAGW-1:0] done_tag_o,
  output logic [STW-1:0]  done_state_o,
  output logic            done_exc_o
);
  logic [STW-1:0] mask;
  logic stall, hold4, haz, accept, commit;

  // stage 1
  logic s1_v, s1_ld, s1_st;
  logic [OPCW-1:0] s1_opc;
  logic [RIW-1:0] s1_rd, s1_rs1, s1_rs2;
  logic [AW-1:0] s1_addr;
  logic [TAGW-1:0] s1_tag;
  // stage 2
  logic s2_v, s2_ld, s2_st;
  logic [OPCW-1:0] s2_opc;
  logic [RIW-1:0] s2_rd, s2_rs1, s2_rs2;
  logic [AW-1:0] s2_addr;
  logic [TAGW-1:0] s2_tag;
  fcode_e s2_fc;
  // stage 3
  logic s3_v, s3_st;
  logic [OPCW-1:0] s3_opc;
  logic [RIW-1:0] s3_rd, s3_rs1, s3_rs2;
  logic [AW-1:0] s3_addr;
  logic [TAGW-1:0] s3_tag;
  fcode_e s3_fc;
  logic [STW-1:0] s3_mt;
  // stage 4
  logic s4_v, s4_wr, s4_st, s4_exc;
  logic [RIW-1:0] s4_rd;
  logic [AW-1:0] s4_addr;
  logic [TAGW-1:0] s4_tag;
  logic [STW-1:0] s4_state;

  logic [STW-1:0] rf1, rf2, src1, src2, res_state;
  logic fwd1, fwd2, need_cache, res_exc;

  assign mask   = width_mask(width_cfg_i);
  assign hold4  = s4_v & s4_st & ~mt_ready_i;
  assign stall  = hold4 | haz;
  assign accept = en_i & in_valid_i & ~stall;
  assign commit = s4_v & ~hold4;
  assign in_ready_o = ~en_i | ~stall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s1_ld <= 1'b0; s1_st <= 1'b0; s1_opc <= '0;
      s1_rd <= '0; s1_rs1 <= '0; s1_rs2 <= '0; s1_addr <= '0; s1_tag <= '0;
      s2_v <= 1'b0; s2_ld <= 1'b0; s2_st <= 1'b0; s2_opc <= '0;
      s2_rd <= '0; s2_rs1 <= '0; s2_rs2 <= '0; s2_addr <= '0; s2_tag <= '0;
      s2_fc <= FC_SLOW;
      s3_v <= 1'b0; s3_st <= 1'b0; s3_opc <= '0; s3_rd <= '0;
      s3_rs1 <= '0; s3_rs2 <= '0; s3_addr <= '0; s3_tag <= '0;
      s3_fc <= FC_SLOW; s3_mt <= '0;
    end else if (!stall) begin
      s1_v <= accept; s1_ld <= in_load_i; s1_st <= in_store_i; s1_opc <= in_opc_i;
      s1_rd <= in_rd_i; s1_rs1 <= in_rs1_i; s1_rs2 <= in_rs2_i;
      s1_addr <= in_addr_i; s1_tag <= in_tag_i;
      s2_v <= s1_v; s2_ld <= s1_ld; s2_st <= s1_st; s2_opc <= s1_opc;
      s2_rd <= s1_rd; s2_rs1 <= s1_rs1; s2_rs2 <= s1_rs2;
      s2_addr <= s1_addr; s2_tag <= s1_tag;
      s2_fc <= fcode_e'(filt_code_i);
      s3_v <= s2_v; s3_st <= s2_st; s3_opc <= s2_opc; s3_rd <= s2_rd;
      s3_rs1 <= s2_rs1; s3_rs2 <= s2_rs2; s3_addr <= s2_addr; s3_tag <= s2_tag;
      s3_fc <= s2_fc;
      s3_mt <= s2_ld ? (mt_rd_data_i & mask) : '0;
    end
  end

  assign filt_opc_o   = s1_opc;
  assign mt_rd_en_o   = s2_v & s2_ld;
  assign mt_rd_addr_o = s2_addr;

  taint_regfile #(.NREG(NREG), .RIW(RIW)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra1_i (s3_rs1),
    .ra2_i (s3_rs2),
    .rd1_o (rf1),
    .rd2_o (rf2),
    .we_i  (commit & s4_wr),
    .wa_i  (s4_rd),
    .wd_i  (s4_state)
  );

  // forward from stage 4 (s4_wr already excludes register 0)
  assign fwd1 = s4_v & s4_wr & (s4_rd == s3_rs1);
  assign fwd2 = s4_v & s4_wr & (s4_rd == s3_rs2);
  assign src1 = (fwd1 ? s4_state : rf1) & mask;
  assign src2 = (fwd2 ? s4_state : rf2) & mask;

  taint_resolve u_res (
    .code_i       (s3_fc),
    .a_i          (src1),
    .b_i          (src2),
    .m_i          (s3_mt),
    .mask_i       (mask),
    .cache_state_i(tpc_state_i),
    .cache_exc_i  (tpc_exc_i),
    .need_cache_o (need_cache),
    .state_o      (res_state),
    .exc_o        (res_exc)
  );

  // cache path may not use a forwarded operand
  assign haz = s3_v & need_cache & (fwd1 | fwd2);

  assign tpc_req_o = s3_v & need_cache & ~stall;
  assign tpc_opc_o = s3_opc;
  assign tpc_s1_o  = src1;
  assign tpc_s2_o  = src2;
  assign tpc_sm_o  = s3_mt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s4_v <= 1'b0; s4_wr <= 1'b0; s4_st <= 1'b0; s4_exc <= 1'b0;
      s4_rd <= '0; s4_addr <= '0; s4_tag <= '0; s4_state <= '0;
    end else if (!hold4) begin
      s4_v     <= s3_v & ~haz;
      s4_wr    <= ~s3_st & (s3_rd != '0);
      s4_st    <= s3_st;
      s4_exc   <= res_exc;
      s4_rd    <= s3_rd;
      s4_addr  <= s3_addr;
      s4_tag   <= s3_tag;
      s4_state <= res_state;
    end
  end

  assign mt_we_o      = s4_v & s4_st;
  assign mt_wr_addr_o = s4_addr;
  assign mt_wr_data_o = s4_state;

  assign done_valid_o = commit | (~en_i & in_valid_i);
  assign done_tag_o   = commit ? s4_tag : in_tag_i;
  assign done_state_o = commit ? s4_state : '0;
  assign done_exc_o   = commit & s4_exc;
endmodule

// File: rtl/taint_pipe_chk.sv
module taint_pipe_chk
  import taint_pkg::*;
#(
  parameter int AW   = 16,
  parameter int OPCW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic [CFGW-1:0] width_cfg_i,
  input logic            in_ready_o,
  input logic [OPCW-1:0] filt_opc_o,
  input logic            mt_we_o,
  input logic            mt_ready_i,
  input logic [AW-1:0]   mt_wr_addr_o,
  input logic [STW-1:0]  mt_wr_data_o,
  input logic            done_valid_o,
  input logic            done_exc_o,
  input logic [STW-1:0]  done_state_o
);
  assert_state_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> (done_state_o & ~width_mask(width_cfg_i)) == '0);

  assert_stall_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !in_ready_o) |=> $stable(filt_opc_o));

  assert_store_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mt_we_o && !mt_ready_i) |=> (mt_we_o && $stable(mt_wr_addr_o) && $stable(mt_wr_data_o)));

  assert_store_no_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mt_we_o && !mt_ready_i) |-> !done_valid_o);

  assert_bypass_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> in_ready_o);

  assert_exc_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_exc_o |-> (done_valid_o && en_i));
endmodule

bind taint_pipe taint_pipe_chk #(.AW(AW), .OPCW(OPCW)) u_chk (.*);

// File: tb/taint_pipe_tb_top.sv
module taint_pipe_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic en_r = 1'b1;
  logic [3:0] cfg_r = 4'd15;
  logic in_valid = 1'b0, in_load = 1'b0, in_store = 1'b0;
  logic [7:0] in_opc = '0, in_tag = '0;
  logic [4:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [15:0] in_addr = '0;
  logic mt_ready = 1'b1;

  logic in_ready_o, mt_rd_en_o, mt_we_o, tpc_req_o, tpc_exc_i, done_valid_o, done_exc_o;
  logic [7:0] filt_opc_o, tpc_opc_o, done_tag_o;
  logic [1:0] filt_code_i;
  logic [15:0] mt_rd_addr_o, mt_rd_data_i, mt_wr_addr_o, mt_wr_data_o;
  logic [15:0] tpc_s1_o, tpc_s2_o, tpc_sm_o, tpc_state_i, done_state_o;

  logic [15:0] tmem [16];
  logic [15:0] mmod [16];
  logic [15:0] rm [32];
  logic [15:0] exp_state [256];
  logic exp_exc [256];
  logic [15:0] got_state [256];
  logic got_exc [256];
  int seen [256];
  int got_cyc [256];
  int acc_cyc [256];
  int cyc = 0;
  int nchk = 0, nfail = 0;
  int next_tag = 0;
  bit finished = 0;

  taint_pipe dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_r), .width_cfg_i(cfg_r),
    .in_valid_i(in_valid), .in_ready_o(in_ready_o), .in_opc_i(in_opc),
    .in_rd_i(in_rd), .in_rs1_i(in_rs1), .in_rs2_i(in_rs2),
    .in_load_i(in_load), .in_store_i(in_store), .in_addr_i(in_addr), .in_tag_i(in_tag),
    .filt_opc_o(filt_opc_o), .filt_code_i(filt_code_i),
    .mt_rd_en_o(mt_rd_en_o), .mt_rd_addr_o(mt_rd_addr_o), .mt_rd_data_i(mt_rd_data_i),
    .mt_we_o(mt_we_o), .mt_wr_addr_o(mt_wr_addr_o), .mt_wr_data_o(mt_wr_data_o),
    .mt_ready_i(mt_ready),
    .tpc_req_o(tpc_req_o), .tpc_opc_o(tpc_opc_o), .tpc_s1_o(tpc_s1_o), .tpc_s2_o(tpc_s2_o),
    .tpc_sm_o(tpc_sm_o), .tpc_state_i(tpc_state_i), .tpc_exc_i(tpc_exc_i),
    .done_valid_o(done_valid_o), .done_tag_o(done_tag_o),
    .done_state_o(done_state_o), .done_exc_o(done_exc_o)
  );

  // external responders: filter code = opcode[1:0]; cache = sum of inputs and opcode
  assign filt_code_i  = filt_opc_o[1:0];
  assign mt_rd_data_i = tmem[mt_rd_addr_o[3:0]];
  assign tpc_state_i  = tpc_s1_o + tpc_s2_o + tpc_sm_o + {8'h00, tpc_opc_o};
  assign tpc_exc_i    = (tpc_opc_o == 8'h80);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mt_we_o && mt_ready) tmem[mt_wr_addr_o[3:0]] <= mt_wr_data_o;
  end

  always begin
    @(negedge clk);
    #2;
    if (done_valid_o) begin
      seen[done_tag_o]++;
      got_state[done_tag_o] = done_state_o;
      got_exc[done_tag_o] = done_exc_o;
      got_cyc[done_tag_o] = cyc;
    end
  end

  function automatic logic [15:0] wmask(input logic [3:0] w);
    return 16'hFFFF >> (15 - int'(w));
  endfunction

  function automatic void model(input logic [7:0] opc, input logic [4:0] rd, rs1, rs2,
                                input logic ld, st, input logic [15:0] addr, input int tg);
    logic [15:0] mk, a, b, m, res;
    logic ex;
    int nz;
    if (!en_r) begin
      exp_state[tg] = '0; exp_exc[tg] = 1'b0;
      return;
    end
    mk = wmask(cfg_r);
    a = rm[rs1] & mk; b = rm[rs2] & mk;
    m = ld ? (mmod[addr[3:0]] & mk) : '0;
    nz = int'(a != 0) + int'(b != 0) + int'(m != 0);
    ex = 1'b0;
    case (opc[1:0])
      2'd3: res = '0;
      2'd1: if (nz == 0) res = '0; else begin res = (a + b + m + {8'h00, opc}) & mk; ex = (opc == 8'h80); end
      2'd2: if (nz <= 1) res = a | b | m; else begin res = (a + b + m + {8'h00, opc}) & mk; ex = (opc == 8'h80); end
      default: begin res = (a + b + m + {8'h00, opc}) & mk; ex = (opc == 8'h80); end
    endcase
    if (st) mmod[addr[3:0]] = res;
    else if (rd != 0) rm[rd] = res;
    exp_state[tg] = res; exp_exc[tg] = ex;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic chk_tag(input string req, input int tg);
    chk({req, " done count"}, seen[tg], 1);
    chk({req, " state"}, got_state[tg], exp_state[tg]);
    chk({req, " exception"}, got_exc[tg], exp_exc[tg]);
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [7:0] opc, input logic [4:0] rd, rs1, rs2,
                      input logic ld, st, input logic [15:0] addr, output int tg);
    bit acc;
    tg = next_tag; next_tag++;
    in_opc = opc; in_rd = rd; in_rs1 = rs1; in_rs2 = rs2;
    in_load = ld; in_store = st; in_addr = addr; in_tag = tg[7:0]; in_valid = 1'b1;
    model(opc, rd, rs1, rs2, ld, st, addr, tg);
    acc = 0;
    while (!acc) begin
      #1;
      acc = in_ready_o;
      if (acc) acc_cyc[tg] = cyc + 1;
      @(negedge clk);
    end
  endtask

  task automatic drain(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 ready after reset", in_ready_o, 1);
    chk("R12 no done after reset", done_valid_o, 0);
    chk("R12 no memory write after reset", mt_we_o, 0);
  endtask

  task automatic t_latency;
    int t;
    send(8'h02, 5'd1, 5'd0, 5'd0, 1'b1, 1'b0, 16'd1, t);
    drain(8);
    chk_tag("R1 R11 load", t);
    chk("R1 latency", got_cyc[t], acc_cyc[t] + 3);
  endtask

  task automatic t_filter;
    int t [6];
    send(8'h02, 5'd2, 5'd0, 5'd0, 1'b1, 1'b0, 16'd3, t[0]);
    send(8'h01, 5'd6, 5'd0, 5'd0, 1'b0, 1'b0, 16'd0, t[1]);
    send(8'h01, 5'd7, 5'd1, 5'd0, 1'b0, 1'b0, 16'd0, t[2]);
    send(8'h02, 5'd8, 5'd1, 5'd2, 1'b0, 1'b0, 16'd0, t[3]);
    send(8'h03, 5'd11, 5'd1, 5'd2, 1'b0, 1'b0, 16'd0, t[4]);
    send(8'h02, 5'd12, 5'd0, 5'd2, 1'b0, 1'b0, 16'd0, t[5]);
    drain(10);
    chk_tag("R11 second load", t[0]);
    chk_tag("R3 zero-opt all zero", t[1]);
    chk_tag("R3 R4 zero-opt via cache", t[2]);
    chk_tag("R3 R4 unary two sources via cache", t[3]);
    chk_tag("R3 clear", t[4]);
    chk_tag("R3 unary single source", t[5]);
    for (int i = 1; i < 6; i++) chk("R1 issue order", got_cyc[t[i]] > got_cyc[t[i-1]], 1);
  endtask

  task automatic t_exception;
    int t;
    send(8'h80, 5'd13, 5'd1, 5'd0, 1'b0, 1'b0, 16'd0, t);
    drain(8);
    chk_tag("R9 R4 cache exception", t);
    chk("R9 exception raised", got_exc[t], 1);
  endtask

  task automatic t_forward;
    int a, b;
    send(8'h02, 5'd3, 5'd1, 5'd0, 1'b0, 1'b0, 16'd0, a);
    send(8'h06, 5'd15, 5'd3, 5'd0, 1'b0, 1'b0, 16'd0, b);
    drain(8);
    chk_tag("R10 producer", a);
    chk_tag("R10 forwarded consumer", b);
    chk("R10 no stall spacing", got_cyc[b] - got_cyc[a], 1);
  endtask

  task automatic t_hazard;
    int a, b;
    send(8'h02, 5'd3, 5'd2, 5'd0, 1'b0, 1'b0, 16'd0, a);
    send(8'h04, 5'd16, 5'd3, 5'd0, 1'b0, 1'b0, 16'd0, b);
    drain(10);
    chk_tag("R7 producer", a);
    chk_tag("R7 cache consumer", b);
    chk("R7 one-cycle stall spacing", got_cyc[b] - got_cyc[a], 2);
  endtask

  task automatic t_r0;
    int a, b;
    send(8'h02, 5'd0, 5'd1, 5'd0, 1'b0, 1'b0, 16'd0, a);
    send(8'h02, 5'd14, 5'd0, 5'd0, 1'b0, 1'b0, 16'd0, b);
    drain(8);
    chk_tag("R2 write to register 0 reports state", a);
    chk("R2 register 0 stays zero", got_state[b], 0);
  endtask

  task automatic t_store;
    int t;
    mt_ready = 1'b0;
    send(8'h02, 5'd0, 5'd0, 5'd1, 1'b0, 1'b1, 16'd7, t);
    drain(6);
    chk("R8 write request held", mt_we_o, 1);
    chk("R8 write address", mt_wr_addr_o, 16'd7);
    chk("R8 write data", mt_wr_data_o, exp_state[t]);
    chk("R8 not done while held", seen[t], 0);
    chk("R8 ready low while held", in_ready_o, 0);
    mt_ready = 1'b1;
    drain(4);
    chk_tag("R8 R11 store completes", t);
    chk("R11 memory taint written", tmem[7], mmod[7]);
  endtask

  task automatic t_width;
    int a, b;
    cfg_r = 4'd3;
    send(8'h02, 5'd4, 5'd0, 5'd0, 1'b1, 1'b0, 16'd2, a);
    send(8'h04, 5'd5, 5'd4, 5'd4, 1'b0, 1'b0, 16'd0, b);
    drain(10);
    chk_tag("R5 masked memory read", a);
    chk("R5 four-bit load", got_state[a], 16'h000D);
    chk_tag("R5 masked cache result", b);
    cfg_r = 4'd15;
  endtask

  task automatic t_bypass;
    int a, b, c;
    send(8'h02, 5'd9, 5'd0, 5'd0, 1'b1, 1'b0, 16'd1, a);
    drain(8);
    en_r = 1'b0;
    send(8'h03, 5'd9, 5'd1, 5'd0, 1'b0, 1'b0, 16'd0, b);
    drain(2);
    chk_tag("R6 bypass passes through", b);
    chk("R6 bypass tag seen", seen[b], 1);
    en_r = 1'b1;
    drain(1);
    send(8'h02, 5'd10, 5'd9, 5'd0, 1'b0, 1'b0, 16'd0, c);
    drain(8);
    chk_tag("R6 register untouched by bypass", c);
    chk("R6 register keeps taint", got_state[c], 16'h0030);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin tmem[i] = '0; mmod[i] = '0; end
    for (int i = 0; i < 32; i++) rm[i] = '0;
    for (int i = 0; i < 256; i++) begin seen[i] = 0; got_state[i] = '0; got_exc[i] = 1'b0; end
    tmem[1] = 16'h0030; mmod[1] = 16'h0030;
    tmem[3] = 16'h0100; mmod[3] = 16'h0100;
    tmem[2] = 16'hABCD; mmod[2] = 16'hABCD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_filter();
    t_exception();
    t_forward();
    t_hazard();
    t_r0();
    t_store();
    t_width();
    t_bypass();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule